// File: doc/BRIEF.md
# Registered Packed Decimal Adder/Subtractor

This block adds or subtracts two packed decimal operands, each byte holding two decimal digits, with a carry-in. Every digit is first summed as a plain 5-bit binary value. A per-digit rule then decides whether the digit produced a decimal carry and applies a nibble correction. The low digit takes the external carry-in. Each higher digit takes the decimal carry of the digit below it.

Subtraction expects the caller to present the subtrahend already ones-complemented. In that mode a carry-in of 1 means no borrow and a carry-out of 0 means a borrow occurred. The overflow output copies the final decimal carry in add mode and inverts it in subtract mode.

An operation is launched by a one-cycle start pulse while the operands are stable. The outcome is captured in registers and announced by a one-cycle done strobe. The registered outcome then holds until the next start.

Top module: `packedBcdAddSub`

## Requirements
- R1: The result port is 9 bits: bit 8 is the carry-out and bits 7:0 are the packed decimal sum, with bits 7:4 the tens digit and bits 3:0 the units digit.
- R2: The units digit's 5-bit sum includes `carryIn`. The tens digit's sum includes the units digit's decimal carry (for example 19+01 gives 020).
- R3: In add mode (`subMode`=0), a digit's decimal carry is set when bit 4 of its 5-bit sum is 1, or when bit 3 is 1 together with bit 2 or bit 1. When that carry is set, 6 is added to the digit's low nibble.
- R4: In subtract mode (`subMode`=1), `opB` holds the ones-complement of the subtrahend. With `carryIn`=1 the result is A−B. With `carryIn`=0 the result is A−B−1.
- R5: In subtract mode, a digit's decimal carry is set only when bit 4 of its 5-bit sum is 1 and bit 3 is not 1 together with bit 2 or bit 1. When that carry is clear, 10 is added to the low nibble modulo 16. A result below zero wraps by 100 and gives carry-out 0.
- R6: `overflow` equals the carry-out in add mode and its inverse in subtract mode.
- R7: `resultValid` is 1 in the cycle that follows the rising clock edge that samples `startEn`=1. It is 0 in every cycle that follows an edge where `startEn`=0.
- R8: `result` and `overflow` hold their values across edges where `startEn`=0, even while the operand inputs change.
- R9: An active-high synchronous `rst` clears `resultValid`, `result` and `overflow` to 0, and a `startEn` sampled during reset launches nothing.
- R10: For every pair of decimal operands 00..99, with both `carryIn` values and in both modes, the sum, carry-out and overflow match decimal arithmetic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| startEn | input | 1 | One-cycle pulse that launches an operation |
| subMode | input | 1 | 0 = add, 1 = subtract (B pre-complemented) |
| opA | input | 8 (4·DIGITS) | Packed decimal operand A |
| opB | input | 8 (4·DIGITS) | Packed decimal operand B, or its ones-complement when subtracting |
| carryIn | input | 1 | Carry into the units digit (1 = no borrow when subtracting) |
| result | output | 9 (4·DIGITS+1) | {carry-out, packed decimal sum} |
| overflow | output | 1 | Carry-out, inverted in subtract mode |
| resultValid | output | 1 | One-cycle strobe marking a fresh result |

## Verification
All three results (the 9-bit result, overflow and the done strobe) are due one clock after the edge that samples the start pulse. They come from a single register stage fed by the combinational digit chain. The bench drives inputs and the start pulse on the falling edge and samples all outputs on the next falling edge, half a cycle after the capturing edge. One further falling edge later it checks that the strobe has dropped and that the result has held while the inputs were changed.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] ADD_FIX = 4'd6;
  localparam logic [DIGIT_W-1:0] SUB_FIX = 4'd10;
  localparam logic [DIGIT_W-1:0] MAX_DIGIT = 4'd9;
  localparam logic [DIGIT_W-1:0] MIN_CPL_DIGIT = 4'd6;

  typedef struct packed {
    logic capture;   // load the computed outcome into the result registers
    logic clearAll;  // synchronous clear of the result registers
  } ctrlStrobes_t;
endpackage

// File: rtl/bcdDigitSlice.sv
`timescale 1ns/1ps
module bcdDigitSlice
  import bcd_pkg::*;
(
  input  logic               subMode,
  input  logic [DIGIT_W-1:0] aDigit,
  input  logic [DIGIT_W-1:0] bDigit,
  input  logic               carryIn,
  output logic [DIGIT_W-1:0] digitOut,
  output logic               carryOut
);
  logic [DIGIT_W:0] rawSum;
  logic             overNine;

  always_comb begin
    rawSum   = {1'b0, aDigit} + {1'b0, bDigit} + {{DIGIT_W{1'b0}}, carryIn};
    // low nibble is 10..15
    overNine = rawSum[3] & (rawSum[2] | rawSum[1]);
    if (!subMode) begin
      carryOut = rawSum[DIGIT_W] | overNine;
      digitOut = carryOut ? rawSum[DIGIT_W-1:0] + ADD_FIX : rawSum[DIGIT_W-1:0];
    end else begin
      carryOut = rawSum[DIGIT_W] & ~overNine;
      digitOut = carryOut ? rawSum[DIGIT_W-1:0] : rawSum[DIGIT_W-1:0] + SUB_FIX;
    end
  end
endmodule

// File: rtl/bcdDatapath.sv
`timescale 1ns/1ps
module bcdDatapath
  import bcd_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * DIGIT_W
)(
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t ctrl,
  input  logic         subMode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W:0]   resultQ,
  output logic         ovfQ
);
  logic [DIGITS:0] carryChain;
  logic [W-1:0]    sumComb;

  assign carryChain[0] = carryIn;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcdDigitSlice u_slice (
      .subMode (subMode),
      .aDigit  (opA[d*DIGIT_W +: DIGIT_W]),
      .bDigit  (opB[d*DIGIT_W +: DIGIT_W]),
      .carryIn (carryChain[d]),
      .digitOut(sumComb[d*DIGIT_W +: DIGIT_W]),
      .carryOut(carryChain[d+1])
    );
  end

  always_ff @(posedge clk) begin
    if (ctrl.clearAll) begin
      resultQ <= '0;
      ovfQ    <= 1'b0;
    end else if (ctrl.capture) begin
      resultQ <= {carryChain[DIGITS], sumComb};
      ovfQ    <= carryChain[DIGITS] ^ subMode;
    end
  end

  // operands hold legal digit codes for the selected mode
  function automatic logic opsLegal(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic sub);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (a[d*DIGIT_W +: DIGIT_W] > MAX_DIGIT) ok = 1'b0;
      if (!sub && b[d*DIGIT_W +: DIGIT_W] > MAX_DIGIT) ok = 1'b0;
      if (sub && b[d*DIGIT_W +: DIGIT_W] < MIN_CPL_DIGIT) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic allDecimal(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++)
      if (v[d*DIGIT_W +: DIGIT_W] > MAX_DIGIT) ok = 1'b0;
    return ok;
  endfunction

  logic inLegal;
  assign inLegal = opsLegal(opA, opB, subMode);

  AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && inLegal) |=> allDecimal(resultQ[W-1:0]));  // R10
  AST_OVF_FROM_CARRY: assert property (@(posedge clk) disable iff (rst)
    ctrl.capture |=> (ovfQ == (resultQ[W] ^ $past(subMode))));  // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capture |=> ($stable(resultQ) && $stable(ovfQ)));  // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    ctrl.clearAll |=> (resultQ == '0 && !ovfQ));  // R9
endmodule

// File: rtl/bcdControl.sv
`timescale 1ns/1ps
module bcdControl
  import bcd_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         startEn,
  output ctrlStrobes_t ctrl,
  output logic         validQ
);
  always_comb begin
    ctrl.clearAll = rst;
    ctrl.capture  = startEn & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= startEn;
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    startEn |=> validQ);  // R7
  AST_VALID_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    validQ |-> $past(startEn));  // R7
  AST_RESET_NO_VALID: assert property (@(posedge clk)
    rst |=> !validQ);  // R9
endmodule

// File: rtl/packedBcdAddSub.sv
`timescale 1ns/1ps
module packedBcdAddSub
  import bcd_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * DIGIT_W
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         startEn,
  input  logic         subMode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W:0]   result,
  output logic         overflow,
  output logic         resultValid
);
  ctrlStrobes_t ctrl;

  bcdControl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .startEn(startEn),
    .ctrl   (ctrl),
    .validQ (resultValid)
  );

  bcdDatapath #(.DIGITS(DIGITS)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .subMode(subMode),
    .opA    (opA),
    .opB    (opB),
    .carryIn(carryIn),
    .resultQ(result),
    .ovfQ   (overflow)
  );
endmodule

// File: tb/sim_packedBcdAddSub.sv
`timescale 1ns/1ps
module sim_packedBcdAddSub;
  logic       clk = 1'b0;
  logic       rst;
  logic       startEn, subMode, carryIn;
  logic [7:0] opA, opB;
  logic [8:0] result;
  logic       overflow, resultValid;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  packedBcdAddSub u0 (
    .clk(clk), .rst(rst), .startEn(startEn), .subMode(subMode),
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .result(result), .overflow(overflow), .resultValid(resultValid)
  );

  // {sub, a, b, ci, expected result[8:0], expected overflow}
  localparam logic [27:0] VECS [0:11] = '{
    {1'b0, 8'h12, 8'h34, 1'b0, 9'h046, 1'b0},  // R1 plain add
    {1'b0, 8'h09, 8'h00, 1'b1, 9'h010, 1'b0},  // R2 carry-in ripples up
    {1'b0, 8'h19, 8'h01, 1'b0, 9'h020, 1'b0},  // R2 units carry into tens
    {1'b0, 8'h08, 8'h08, 1'b0, 9'h016, 1'b0},  // R3 bit-4 carry, +6
    {1'b0, 8'h99, 8'h99, 1'b1, 9'h199, 1'b1},  // R3 largest add
    {1'b0, 8'h50, 8'h50, 1'b0, 9'h100, 1'b1},  // R6 add overflow
    {1'b1, 8'h46, 8'hED, 1'b1, 9'h134, 1'b0},  // R4 46-12
    {1'b1, 8'h46, 8'hED, 1'b0, 9'h133, 1'b0},  // R4 46-12-1
    {1'b1, 8'h40, 8'hFE, 1'b1, 9'h139, 1'b0},  // R5 units borrow, +10
    {1'b1, 8'h00, 8'hFE, 1'b1, 9'h099, 1'b1},  // R5 wrap below zero
    {1'b1, 8'h00, 8'hFF, 1'b0, 9'h099, 1'b1},  // R5 borrow-in only
    {1'b1, 8'h99, 8'h66, 1'b1, 9'h100, 1'b0}   // R4 99-99
  };

  task automatic check(input bit ok, input string tag, input logic [9:0] act,
                       input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] toBcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  // decimal model: returns {overflow, carry, sum}
  function automatic logic [9:0] model(input bit sub, input int a, input int b,
                                       input bit ci);
    int t;
    bit cy;
    if (!sub) begin
      t = a + b + int'(ci);
      cy = (t >= 100);
      if (cy) t -= 100;
      return {cy, cy, toBcd(t)};
    end
    t = a - b - (ci ? 0 : 1);
    cy = (t >= 0);
    if (!cy) t += 100;
    return {~cy, cy, toBcd(t)};
  endfunction

  // drive at a falling edge, pulse start one cycle, sample half a cycle after capture
  task automatic runOp(input bit sub, input logic [7:0] a, input logic [7:0] b,
                       input bit ci);
    @(negedge clk);
    subMode = sub; opA = a; opB = b; carryIn = ci; startEn = 1'b1;
    @(negedge clk);
    startEn = 1'b0;
  endtask

  initial begin
    rst = 1'b1; startEn = 1'b0; subMode = 1'b0; opA = '0; opB = '0; carryIn = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(result == 9'h0, "R9 result after reset", {1'b0, result}, 10'h0);
    check(!overflow, "R9 overflow after reset", {9'h0, overflow}, 10'h0);
    check(!resultValid, "R9 valid after reset", {9'h0, resultValid}, 10'h0);
    rst = 1'b0;

    // table of directed vectors
    for (int i = 0; i < 12; i++) begin
      logic [27:0] v;
      v = VECS[i];
      runOp(v[27], v[26:19], v[18:11], v[10]);
      check(resultValid, "R7 valid one cycle after start", {9'h0, resultValid}, 10'h1);
      check(result == v[9:1] && overflow == v[0], "R1 R3 R5 R6 table vector",
            {overflow, result}, {v[0], v[9:1]});
    end

    // R7 single-cycle strobe, R8 hold while inputs move
    runOp(1'b0, 8'h27, 8'h38, 1'b0);  // 065
    opA = 8'h99; opB = 8'h99; carryIn = 1'b1; subMode = 1'b1;
    @(negedge clk);
    check(!resultValid, "R7 strobe drops", {9'h0, resultValid}, 10'h0);
    check(result == 9'h065 && !overflow, "R8 result held", {overflow, result}, 10'h065);
    repeat (3) @(negedge clk);
    check(result == 9'h065 && !overflow, "R8 result held longer", {overflow, result}, 10'h065);

    // R9 reset mid-run, with start asserted during reset
    runOp(1'b0, 8'h99, 8'h99, 1'b1);  // 199, overflow 1
    rst = 1'b1; startEn = 1'b1;
    @(negedge clk);
    startEn = 1'b0; rst = 1'b0;
    check(result == 9'h0 && !overflow, "R9 reset clears result", {overflow, result}, 10'h0);
    @(negedge clk);
    check(!resultValid, "R9 no start during reset", {9'h0, resultValid}, 10'h0);
    check(result == 9'h0, "R9 result still clear", {1'b0, result}, 10'h0);

    // R10 exhaustive decimal sweep
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 100; a++)
        for (int b = 0; b < 100; b++)
          for (int c = 0; c < 2; c++) begin
            logic [9:0] exp;
            exp = model(s[0], a, b, c[0]);
            runOp(s[0], toBcd(a), s[0] ? ~toBcd(b) : toBcd(b), c[0]);
            check(resultValid && {overflow, result} == exp, "R10 exhaustive",
                  {overflow, result}, exp);
          end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule